// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a clocked user port and an asynchronous byte-wide static RAM with a 21-bit address. It accepts one read or write at a time over a request/ready handshake. It then plays out the matching sequence on the active-low chip-select, write-strobe and output-enable pins. Each strobe phase is held for a whole number of clock cycles. These counts are worked out at elaboration time from the memory's minimum timing limits (given in picoseconds) and the clock period.

A write runs in three phases. First comes one setup cycle with the chip selected and the address stable. Then comes a write-strobe pulse of `WP_CYC` cycles, with output enable held high so that the shorter pulse limit applies. Last comes one hold cycle in which the strobe is released and the data is still driven. A read holds output enable low for `RD_CYC` cycles and captures the data pins on the last of them. Between operations the controller spends one idle cycle with every strobe high and the bus released. This idle cycle is also the turnaround between a write and a following read.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is held, and whenever the controller is idle, chip select, write strobe and output enable are all high (1), the data bus is not driven, and `reqReady` is 1.
- R2: A request is taken only on a clock edge where `reqValid` and `reqReady` are both 1. `reqReady` is 0 from the next cycle until the operation ends. A `reqValid` raised while `reqReady` is 0 and dropped again before `reqReady` returns has no effect on memory contents.
- R3: The write strobe goes low only while chip select is low and output enable is high. Each low pulse lasts exactly `WP_CYC` cycles.
- R4: During a write, the data bus is driven for the whole strobe pulse and for one hold cycle after the strobe rises. The address stays stable for as long as chip select is low.
- R5: A write stores `reqWrData` at `reqAddr`. A later read of that address returns it.
- R6: A read holds output enable low, with the write strobe high, for exactly `RD_CYC` cycles. The data pins are captured at the end of the last of those cycles, and `rdValid` is 1 for exactly one cycle with `rdData` holding that byte.
- R7: The bus is never driven while output enable is low. At least one cycle with the bus released separates the last driven cycle from output enable falling.
- R8: Address and write data are latched when the request is taken. Changing `reqAddr` or `reqWrData` afterwards does not change the operation.
- R9: `WP_CYC` is the largest of: ceil(pulse limit / period), ceil(data setup / period), ceil(address-to-end / period) − 1, ceil(select-to-end / period) − 1, ceil(write cycle / period) − 2, and 1. `RD_CYC` is the largest of the ceilings of the read cycle, address access, select access and output-enable access limits, and 1. With a 4 ns clock and the default limits these are 2 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Controller can take a request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Byte address of the request |
| reqWrData | input | DATA_W | Byte to write |
| rdValid | output | 1 | One-cycle pulse: rdData holds read result |
| rdData | output | DATA_W | Captured read byte |
| memAddr | output | ADDR_W | Address pins of the RAM |
| memCeN | output | 1 | Chip select, active low |
| memOeN | output | 1 | Output enable, active low |
| memWeN | output | 1 | Write strobe, active low |
| memDout | output | DATA_W | Byte to drive onto the data pins |
| memDoutEn | output | 1 | 1 = data pins driven by controller |
| memDin | input | DATA_W | Byte read from the data pins |

## Verification
The memory model in the bench returns a junk byte until output enable has been low long enough. A controller that captured read data a cycle early would therefore return junk instead of the stored byte. The model commits a write only on the rising edge of the write strobe, and only if the data is still being driven at that moment. A design that released the bus on the same edge, or that shortened the pulse, would lose the write or trip the pulse-width check. Writes followed at once by reads exercise the turnaround: any overlap of a driven bus with output enable low is counted as a failure. Requests raised while busy, and input changes after acceptance, would corrupt the readback if the controller sampled its inputs at the wrong time.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_W_SETUP,
    ST_W_PULSE,
    ST_W_HOLD,
    ST_R_ACCESS
  } ctrlState_e;

  // strobes from control to datapath, active high meaning "asserted"
  typedef struct packed {
    logic selChip;
    logic wrStrobe;
    logic rdStrobe;
    logic busDrive;
    logic capture;
    logic sample;
  } strobeCtl_t;

  function automatic int cyclesFor(input int limitPs, input int periodPs);
    return (limitPs + periodPs - 1) / periodPs;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int WP_CYC = 1,
  parameter int RD_CYC = 1,
  localparam int CNT_W = $clog2(maxOf(WP_CYC, RD_CYC) + 1)
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqWrite,
  output logic       reqReady,
  output strobeCtl_t ctl
);

  ctrlState_e state, nextState;
  logic [CNT_W-1:0] phaseCnt;
  logic pulseDone, readDone;

  assign pulseDone = (phaseCnt == CNT_W'(WP_CYC - 1));
  assign readDone  = (phaseCnt == CNT_W'(RD_CYC - 1));

  always_comb begin
    nextState = state;
    case (state)
      ST_IDLE:     if (reqValid) nextState = reqWrite ? ST_W_SETUP : ST_R_ACCESS;
      ST_W_SETUP:  nextState = ST_W_PULSE;
      ST_W_PULSE:  if (pulseDone) nextState = ST_W_HOLD;
      ST_W_HOLD:   nextState = ST_IDLE;
      ST_R_ACCESS: if (readDone) nextState = ST_IDLE;
      default:     nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      phaseCnt <= '0;
    end else begin
      state    <= nextState;
      phaseCnt <= (nextState != state) ? '0 : phaseCnt + 1'b1;
    end
  end

  // pin strobes are decoded from the next state so the datapath can register them
  always_comb begin
    ctl.selChip  = (nextState != ST_IDLE);
    ctl.wrStrobe = (nextState == ST_W_PULSE);
    ctl.rdStrobe = (nextState == ST_R_ACCESS);
    ctl.busDrive = (nextState == ST_W_PULSE) || (nextState == ST_W_HOLD);
    ctl.capture  = (state == ST_IDLE) && reqValid;
    ctl.sample   = (state == ST_R_ACCESS) && readDone;
  end

  assign reqReady = (state == ST_IDLE);

endmodule

// File: rtl/sram_ctrl_datapath.sv
module sram_ctrl_datapath
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 21,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeCtl_t        ctl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWrData,
  input  logic [DATA_W-1:0] memDin,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCeN,
  output logic              memOeN,
  output logic              memWeN,
  output logic [DATA_W-1:0] memDout,
  output logic              memDoutEn,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memCeN    <= 1'b1;
      memOeN    <= 1'b1;
      memWeN    <= 1'b1;
      memDoutEn <= 1'b0;
    end else begin
      memCeN    <= ~ctl.selChip;
      memOeN    <= ~ctl.rdStrobe;
      memWeN    <= ~ctl.wrStrobe;
      memDoutEn <= ctl.busDrive;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memAddr <= '0;
      memDout <= '0;
    end else if (ctl.capture) begin
      memAddr <= reqAddr;
      memDout <= reqWrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= ctl.sample;
      if (ctl.sample) rdData <= memDin;
    end
  end

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W        = 21,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_PS = 10000,
  parameter int T_WCYC_PS     = 10000,
  parameter int T_SEL_END_PS  = 8000,
  parameter int T_ADR_END_PS  = 8000,
  parameter int T_PULSE_PS    = 8000,
  parameter int T_DSETUP_PS   = 6000,
  parameter int T_RCYC_PS     = 10000,
  parameter int T_ADR_ACC_PS  = 10000,
  parameter int T_SEL_ACC_PS  = 10000,
  parameter int T_OE_ACC_PS   = 6500,
  localparam int WP_CYC = maxOf(maxOf(maxOf(cyclesFor(T_PULSE_PS, CLK_PERIOD_PS),
                                            cyclesFor(T_DSETUP_PS, CLK_PERIOD_PS)),
                                      maxOf(cyclesFor(T_ADR_END_PS, CLK_PERIOD_PS) - 1,
                                            cyclesFor(T_SEL_END_PS, CLK_PERIOD_PS) - 1)),
                                maxOf(cyclesFor(T_WCYC_PS, CLK_PERIOD_PS) - 2, 1)),
  localparam int RD_CYC = maxOf(maxOf(maxOf(cyclesFor(T_RCYC_PS, CLK_PERIOD_PS),
                                            cyclesFor(T_ADR_ACC_PS, CLK_PERIOD_PS)),
                                      maxOf(cyclesFor(T_SEL_ACC_PS, CLK_PERIOD_PS),
                                            cyclesFor(T_OE_ACC_PS, CLK_PERIOD_PS))),
                                1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWrData,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCeN,
  output logic              memOeN,
  output logic              memWeN,
  output logic [DATA_W-1:0] memDout,
  output logic              memDoutEn,
  input  logic [DATA_W-1:0] memDin
);

  strobeCtl_t ctl;

  sram_ctrl_fsm #(
    .WP_CYC(WP_CYC),
    .RD_CYC(RD_CYC)
  ) u_fsm (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqReady (reqReady),
    .ctl      (ctl)
  );

  sram_ctrl_datapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .reqAddr   (reqAddr),
    .reqWrData (reqWrData),
    .memDin    (memDin),
    .memAddr   (memAddr),
    .memCeN    (memCeN),
    .memOeN    (memOeN),
    .memWeN    (memWeN),
    .memDout   (memDout),
    .memDoutEn (memDoutEn),
    .rdValid   (rdValid),
    .rdData    (rdData)
  );

endmodule

// File: rtl/sram_ctrl_checker.sv
module sram_ctrl_checker #(
  parameter int ADDR_W = 21,
  parameter int WP_CYC = 1,
  parameter int RD_CYC = 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqReady,
  input logic              rdValid,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memCeN,
  input logic              memOeN,
  input logic              memWeN,
  input logic              memDoutEn
);

  logic [15:0] weLowCnt, oeLowCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      weLowCnt <= '0;
      oeLowCnt <= '0;
    end else begin
      weLowCnt <= memWeN ? '0 : weLowCnt + 1'b1;
      oeLowCnt <= memOeN ? '0 : oeLowCnt + 1'b1;
    end
  end

  AST_IDLE_PINS: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (memCeN && memWeN && memOeN && !memDoutEn)); // R1
  AST_WE_QUALIFIED: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> (!memCeN && memOeN)); // R3
  AST_WE_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |-> (weLowCnt == 16'(WP_CYC))); // R3
  AST_WE_DRIVEN: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> memDoutEn); // R4
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |-> memDoutEn); // R4
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (!memCeN && !$past(memCeN)) |-> $stable(memAddr)); // R4
  AST_OE_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memOeN) |-> (oeLowCnt == 16'(RD_CYC))); // R6
  AST_RDVALID_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> !rdValid); // R6
  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rstN)
    !memOeN |-> !memDoutEn); // R7
  AST_TURNAROUND: assert property (@(posedge clk) disable iff (!rstN)
    $fell(memOeN) |-> !$past(memDoutEn)); // R7

endmodule

bind sram_async_ctrl sram_ctrl_checker #(
  .ADDR_W(ADDR_W),
  .WP_CYC(WP_CYC),
  .RD_CYC(RD_CYC)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .reqReady  (reqReady),
  .rdValid   (rdValid),
  .memAddr   (memAddr),
  .memCeN    (memCeN),
  .memOeN    (memOeN),
  .memWeN    (memWeN),
  .memDoutEn (memDoutEn)
);

// File: tb/sim_sram_async_ctrl.sv
module sim_sram_async_ctrl;

  localparam int EXP_WP = 2;  // R9: 4 ns clock, 8 ns pulse
  localparam int EXP_RD = 3;  // R9: 4 ns clock, 10 ns access

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [20:0] reqAddr = '0;
  logic [7:0]  reqWrData = '0;
  logic reqReady, rdValid, memCeN, memOeN, memWeN, memDoutEn;
  logic [7:0] rdData, memDout;
  logic [7:0] memDin = 8'h5A;
  logic [20:0] memAddr;

  int nTests = 0, nFail = 0, cycles = 0;
  logic [7:0] memArr [int];
  logic [7:0] refArr [int];
  logic [7:0] expQ [$];
  int accessCnt = 0, weCnt = 0, oeCnt = 0;
  logic prevDrive = 1'b0;

  always #2 clk = ~clk;

  sram_async_ctrl #(.CLK_PERIOD_PS(4000)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWrData(reqWrData),
    .rdValid(rdValid), .rdData(rdData), .memAddr(memAddr), .memCeN(memCeN),
    .memOeN(memOeN), .memWeN(memWeN), .memDout(memDout),
    .memDoutEn(memDoutEn), .memDin(memDin)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] rdArr(input logic [7:0] arr [int], input int a);
    return arr.exists(a) ? arr[a] : 8'h00;
  endfunction

  // memory model: commits on the write-ending edge of the strobe
  always @(posedge memWeN) if (rstN) begin
    check(!memCeN && memDoutEn, "R4 data driven at write end", memDoutEn, 1);
    memArr[int'(memAddr)] = memDout;
  end

  // memory model: data valid only after enough access time
  always @(posedge clk) begin
    accessCnt <= (memCeN || memOeN) ? 0 : accessCnt + 1;
    cycles <= cycles + 1;
  end
  always @(negedge clk)
    memDin <= (!memCeN && memWeN && !memOeN && accessCnt >= EXP_RD - 1)
              ? rdArr(memArr, int'(memAddr)) : 8'h5A;

  // pin monitor and scoreboard
  always @(negedge clk) if (rstN) begin
    if (!memWeN) begin
      weCnt++;
      if (memCeN || !memOeN) check(0, "R3 strobe while not selected or OE low", memOeN, 1);
    end else if (weCnt != 0) begin
      check(weCnt == EXP_WP, "R3 write pulse width", weCnt, EXP_WP);
      weCnt = 0;
    end
    if (!memOeN) begin
      if (oeCnt == 0 && prevDrive) check(0, "R7 no turnaround cycle", 1, 0);
      if (memDoutEn) check(0, "R7 bus driven with OE low", 1, 0);
      if (!memWeN) check(0, "R6 write strobe during read", 0, 1);
      oeCnt++;
    end else if (oeCnt != 0) begin
      check(oeCnt == EXP_RD, "R6 read phase length", oeCnt, EXP_RD);
      oeCnt = 0;
    end
    prevDrive = memDoutEn;
    if (rdValid) begin
      if (expQ.size() == 0) check(0, "R6 unexpected rdValid", rdData, 0);
      else begin
        logic [7:0] e;
        e = expQ.pop_front();
        check(rdData == e, "R5/R6 read data", rdData, e);
      end
    end
  end

  task automatic doReq(input logic wr, input logic [20:0] a, input logic [7:0] d);
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWrData = d;
    @(negedge clk);
    check(!reqReady, "R2 ready low after accept", reqReady, 0);
    if (wr) refArr[int'(a)] = d;
    else expQ.push_back(rdArr(refArr, int'(a)));
    reqValid = 1'b0;
    reqAddr = ~a; reqWrData = ~d;   // R8: inputs change after acceptance
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(memCeN && memWeN && memOeN && !memDoutEn, "R1 pins in reset", {memCeN, memWeN, memOeN, memDoutEn}, 4'hE);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady && memCeN && memWeN && memOeN && !memDoutEn, "R1 idle after reset",
          {reqReady, memCeN, memWeN, memOeN, memDoutEn}, 5'h1E);
    check(!rdValid, "R1 rdValid low", rdValid, 0);

    doReq(1, 21'h000000, 8'h3C);
    doReq(1, 21'h1FFFFF, 8'hC3);
    doReq(0, 21'h000000, 8'h00);   // R7 write then read turnaround
    doReq(0, 21'h1FFFFF, 8'h00);
    doReq(0, 21'h0ABCDE, 8'h00);   // unwritten address reads zero
    for (int i = 0; i < 8; i++) doReq(1, 21'h00400 + 21'(i * 37), 8'(i * 29 + 1));
    for (int i = 7; i >= 0; i--) doReq(0, 21'h00400 + 21'(i * 37), 8'h00);
    doReq(1, 21'h000100, 8'h77);
    // R2: a request raised while busy and dropped before ready returns is ignored
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = 21'h000100; reqWrData = 8'hEE;
    @(negedge clk);
    check(!reqReady, "R2 busy during write", reqReady, 0);
    @(negedge clk);
    reqValid = 1'b0;
    doReq(0, 21'h000100, 8'h00);
    doReq(1, 21'h000101, 8'h11);
    doReq(1, 21'h000101, 8'h22);   // overwrite
    doReq(0, 21'h000101, 8'h00);
    doReq(0, 21'h000101, 8'h00);   // back-to-back reads
    while (expQ.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    check(reqReady && memCeN && memWeN && memOeN && !memDoutEn, "R1 idle at end",
          {reqReady, memCeN, memWeN, memOeN, memDoutEn}, 5'h1E);
    check(rdArr(memArr, 32'h100) == 8'h77, "R8 model contents", rdArr(memArr, 32'h100), 8'h77);
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    check(0, "watchdog expired", cycles, 0);
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule